// File: doc/BRIEF.md
# Data Object Request/Response Mailbox

This block is a 32-bit configuration-space register slave that carries request/response exchanges between host software and protocol engines inside the device. Software writes a request one doubleword at a time into a write mailbox and then issues a go command. The block checks the request in two ways. The first header doubleword must match an entry in a table of supported protocols, set by parameter. The doubleword count that software wrote must equal the length field of the second header doubleword. A request that passes is handed to an external protocol responder through a start/done handshake.

The responder reads the stored request through a read port. It appends its response doublewords into a read buffer and then signals completion. Software polls or waits for an interrupt request, then drains the response: it reads the read mailbox and acknowledges each doubleword by writing that same register. An abort command returns the whole exchange to idle at any time.

Registers sit at byte offsets inside the capability: 0x04 capability, 0x08 control, 0x0C status, 0x10 write mailbox, 0x14 read mailbox. Any other offset reads 0 and ignores writes.

Top module: `dobj_mailbox`

## Requirements
- R1: After reset, status (0x0C) and control (0x08) read 0 and no request is pending.
- R2: The capability register (0x04) reads bit 0 = interrupt supported and bits 11:1 = interrupt message number, with all other bits 0.
- R3: A control read returns only the interrupt-enable bit at bit 1. The abort bit (0) and the go bit (31) always read 0, and every control write loads the interrupt-enable bit from bit 1.
- R4: Each write to 0x10 stores one doubleword at the next position. A go write matches only if three things hold: header doubleword 0 equals `{8'h00, type[7:0], vendor[15:0]}` of a table entry, the count written equals header doubleword 1 bits 17:0, and the count is at least 2. A matching go raises `rsp_start` for one cycle with the lowest matching table index on `rsp_prot_idx`, and busy (status bit 0) stays high until `rsp_done`.
- R5: A go with no matching protocol or with a count that differs from the header length is silently discarded. It starts no responder, busy and ready stay 0, and both mailboxes are emptied, so the next request starts at position 0.
- R6: Writes beyond DEPTH doublewords are dropped and force a discard at the next go, even when the header length equals DEPTH.
- R7: `rsp_done` without `rsp_discard` sets ready (status bit 31). While ready, 0x14 reads the response doubleword at the current read index, and a read never advances the index.
- R8: A write of any value to 0x14 while ready advances the read index by one. The write that passes the last response doubleword clears ready and empties both mailboxes.
- R9: While not ready, 0x14 reads 0 and writes to it have no effect.
- R10: `rsp_done` with `rsp_discard` sets error (status bit 2), leaves ready at 0 and empties both mailboxes.
- R11: A control write with bit 0 set clears busy, ready, error and all mailbox counters. It wins over bit 31 set in the same write, and a later `rsp_done` for the aborted request is ignored.
- R12: When ready or error becomes set while interrupts are supported and enabled, `irq` pulses high for exactly one cycle and interrupt status (status bit 1) is set. Interrupt status clears only on a status write with bit 1 set.
- R13: A go write while busy or ready is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 8 | Byte offset of the register inside the capability |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the register at `cfg_addr` (combinational) |
| req_rd_addr | input | 4 | Responder read index into the request buffer |
| req_rd_data | output | 32 | Request doubleword at `req_rd_addr` |
| rsp_start | output | 1 | One-cycle pulse that dispatches an accepted request |
| rsp_prot_idx | output | 2 | Table index of the matched protocol |
| rsp_wr_en | input | 1 | Responder appends one response doubleword |
| rsp_wr_data | input | 32 | Response doubleword |
| rsp_done | input | 1 | Responder finished the current request |
| rsp_discard | input | 1 | With `rsp_done`: the responder rejected the request |
| irq | output | 1 | Interrupt request pulse |

## Verification
Some properties are checked on every cycle. Busy and ready are never high together. A dispatch pulse appears only while busy. An abort always leaves busy, ready and error low. Each interrupt pulse lasts one cycle and coincides with ready or error being set. The read mailbox reads zero whenever ready is low, and a go with an unmatched header or an overflowed buffer never leaves the block busy. Other behaviour only the bench scenarios can show: the exact response doublewords returned in order, that a read does not advance the index, the length and overflow discards, and the interrupt-enable gating. They also show that a discard really empties the mailboxes, which is proved when the next request dispatches correctly.

// File: rtl/dobj_mbx_pkg.sv
package dobj_mbx_pkg;

  // Register byte offsets inside the capability
  localparam logic [7:0] OFS_CAP = 8'h04;
  localparam logic [7:0] OFS_CTL = 8'h08;
  localparam logic [7:0] OFS_STS = 8'h0C;
  localparam logic [7:0] OFS_WMB = 8'h10;
  localparam logic [7:0] OFS_RMB = 8'h14;

  // Control bits
  localparam int CTL_ABORT = 0;
  localparam int CTL_IE    = 1;
  localparam int CTL_GO    = 31;

  // Status bits
  localparam int STS_BUSY = 0;
  localparam int STS_INT  = 1;
  localparam int STS_ERR  = 2;
  localparam int STS_RDY  = 31;

  // Header length field width (doublewords)
  localparam int LEN_W = 18;

  // One table entry: {type, vendor}
  localparam int PROT_ENTRY_W = 24;

  function automatic logic [PROT_ENTRY_W-1:0] prot_code(input logic [15:0] vendor,
                                                         input logic [7:0]  otype);
    return {otype, vendor};
  endfunction

endpackage

// File: rtl/dobj_mbx_dwbuf.sv
module dobj_mbx_dwbuf #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

  // R4: a stored doubleword is always a defined value
  assert_store_defined_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(wdata));

endmodule

// File: rtl/dobj_mbx_pmatch.sv
module dobj_mbx_pmatch
  import dobj_mbx_pkg::*;
#(
  parameter int NPROT = 3,
  parameter logic [NPROT*PROT_ENTRY_W-1:0] PROT_TBL = '0,
  localparam int IDX_W = (NPROT > 1) ? $clog2(NPROT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      hdr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [NPROT-1:0] match;

  for (genvar g = 0; g < NPROT; g++) begin : g_cmp
    assign match[g] = (hdr == {8'h00, PROT_TBL[g*PROT_ENTRY_W +: PROT_ENTRY_W]});
  end

  // Lowest matching index wins
  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = NPROT - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  // R4: a reported index always names a real table entry
  assert_idx_in_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(idx) < NPROT));

endmodule

// File: rtl/dobj_mailbox.sv
module dobj_mailbox
  import dobj_mbx_pkg::*;
#(
  parameter int          DEPTH    = 16,
  parameter int          NPROT    = 3,
  parameter logic [NPROT*PROT_ENTRY_W-1:0] PROT_TBL =
    {8'h07, 16'hABCD, 8'h01, 16'h0001, 8'h00, 16'h0001},
  parameter bit          INTR_SUP = 1'b1,
  parameter logic [10:0] MSG_NUM  = 11'd5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (NPROT > 1) ? $clog2(NPROT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [PTR_W-1:0] req_rd_addr,
  output logic [31:0]      req_rd_data,
  output logic             rsp_start,
  output logic [IDX_W-1:0] rsp_prot_idx,
  input  logic             rsp_wr_en,
  input  logic [31:0]      rsp_wr_data,
  input  logic             rsp_done,
  input  logic             rsp_discard,
  output logic             irq
);

  // ---------------------------------------------------------------
  // Reset: asynchronous assert, synchronous release
  // ---------------------------------------------------------------
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // ---------------------------------------------------------------
  // State
  // ---------------------------------------------------------------
  logic [CNT_W-1:0] wcnt_q, wcnt_n;
  logic [CNT_W-1:0] rcnt_q, rcnt_n;
  logic [CNT_W-1:0] rptr_q, rptr_n;
  logic             ovf_q, ovf_n;
  logic [31:0]      hdr0_q, hdr0_n;
  logic [LEN_W-1:0] hlen_q, hlen_n;
  logic             busy_q, busy_n;
  logic             rdy_q, rdy_n;
  logic             err_q, err_n;
  logic             ist_q, ist_n;
  logic             ie_q, ie_n;
  logic             start_q, start_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             irq_q, irq_n;

  // ---------------------------------------------------------------
  // Decode
  // ---------------------------------------------------------------
  logic wr_ctl, wr_sts, wr_wmb, wr_rmb, idle;
  logic is_abort, is_go;

  assign wr_ctl   = cfg_wr && (cfg_addr == OFS_CTL);
  assign wr_sts   = cfg_wr && (cfg_addr == OFS_STS);
  assign wr_wmb   = cfg_wr && (cfg_addr == OFS_WMB);
  assign wr_rmb   = cfg_wr && (cfg_addr == OFS_RMB);
  assign idle     = !busy_q && !rdy_q;
  assign is_abort = wr_ctl && cfg_wdata[CTL_ABORT];
  assign is_go    = wr_ctl && !cfg_wdata[CTL_ABORT] && cfg_wdata[CTL_GO];

  // ---------------------------------------------------------------
  // Sub-blocks
  // ---------------------------------------------------------------
  logic             wbuf_we, rbuf_we;
  logic [31:0]      rbuf_rdata;
  logic             prot_hit;
  logic [IDX_W-1:0] prot_idx;

  assign wbuf_we = wr_wmb && idle && (wcnt_q < CNT_W'(DEPTH));
  assign rbuf_we = busy_q && rsp_wr_en && (rcnt_q < CNT_W'(DEPTH));

  dobj_mbx_dwbuf #(.DEPTH(DEPTH), .DW(32)) u_wbuf (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (wbuf_we),
    .waddr (wcnt_q[PTR_W-1:0]),
    .wdata (cfg_wdata),
    .raddr (req_rd_addr),
    .rdata (req_rd_data)
  );

  dobj_mbx_dwbuf #(.DEPTH(DEPTH), .DW(32)) u_rbuf (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (rbuf_we),
    .waddr (rcnt_q[PTR_W-1:0]),
    .wdata (rsp_wr_data),
    .raddr (rptr_q[PTR_W-1:0]),
    .rdata (rbuf_rdata)
  );

  dobj_mbx_pmatch #(.NPROT(NPROT), .PROT_TBL(PROT_TBL)) u_match (
    .clk   (clk),
    .rst_n (rst_i_n),
    .hdr   (hdr0_q),
    .hit   (prot_hit),
    .idx   (prot_idx)
  );

  // ---------------------------------------------------------------
  // Acceptance check for a go command
  // ---------------------------------------------------------------
  logic len_ok, req_ok;
  assign len_ok = (wcnt_q >= CNT_W'(2)) && (LEN_W'(wcnt_q) == hlen_q);
  assign req_ok = prot_hit && !ovf_q && len_ok;

  // ---------------------------------------------------------------
  // Next state
  // ---------------------------------------------------------------
  always_comb begin
    logic clr;
    clr     = 1'b0;
    wcnt_n  = wcnt_q;
    rcnt_n  = rcnt_q;
    rptr_n  = rptr_q;
    ovf_n   = ovf_q;
    hdr0_n  = hdr0_q;
    hlen_n  = hlen_q;
    busy_n  = busy_q;
    rdy_n   = rdy_q;
    err_n   = err_q;
    ist_n   = ist_q;
    ie_n    = ie_q;
    start_n = 1'b0;
    idx_n   = idx_q;

    // Request append
    if (wr_wmb && idle) begin
      if (wcnt_q == CNT_W'(DEPTH)) begin
        ovf_n = 1'b1;
      end else begin
        wcnt_n = wcnt_q + CNT_W'(1);
        if (wcnt_q == CNT_W'(0)) hdr0_n = cfg_wdata;
        if (wcnt_q == CNT_W'(1)) hlen_n = cfg_wdata[LEN_W-1:0];
      end
    end

    // Response append
    if (rbuf_we) begin
      rcnt_n = rcnt_q + CNT_W'(1);
    end

    // Responder completion
    if (busy_q && rsp_done) begin
      busy_n = 1'b0;
      if (rsp_discard) begin
        err_n = 1'b1;
        clr   = 1'b1;
      end else begin
        rdy_n = 1'b1;
      end
    end

    // Response drain
    if (wr_rmb && rdy_q) begin
      if ((rptr_q + CNT_W'(1)) >= rcnt_q) begin
        rdy_n = 1'b0;
        clr   = 1'b1;
      end else begin
        rptr_n = rptr_q + CNT_W'(1);
      end
    end

    // Interrupt status clear
    if (wr_sts && cfg_wdata[STS_INT]) begin
      ist_n = 1'b0;
    end

    // Control
    if (wr_ctl) begin
      ie_n = cfg_wdata[CTL_IE];
    end
    if (is_abort) begin
      busy_n = 1'b0;
      rdy_n  = 1'b0;
      err_n  = 1'b0;
      clr    = 1'b1;
    end else if (is_go && idle) begin
      if (req_ok) begin
        busy_n  = 1'b1;
        start_n = 1'b1;
        idx_n   = prot_idx;
      end else begin
        clr = 1'b1;
      end
    end

    if (clr) begin
      wcnt_n = '0;
      rcnt_n = '0;
      rptr_n = '0;
      ovf_n  = 1'b0;
    end

    irq_n = INTR_SUP && ie_q && ((rdy_n && !rdy_q) || (err_n && !err_q));
    if (irq_n) ist_n = 1'b1;
  end

  // ---------------------------------------------------------------
  // Registers
  // ---------------------------------------------------------------
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      rptr_q  <= '0;
      ovf_q   <= 1'b0;
      hdr0_q  <= '0;
      hlen_q  <= '0;
      busy_q  <= 1'b0;
      rdy_q   <= 1'b0;
      err_q   <= 1'b0;
      ist_q   <= 1'b0;
      ie_q    <= 1'b0;
      start_q <= 1'b0;
      idx_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      wcnt_q  <= wcnt_n;
      rcnt_q  <= rcnt_n;
      rptr_q  <= rptr_n;
      ovf_q   <= ovf_n;
      hdr0_q  <= hdr0_n;
      hlen_q  <= hlen_n;
      busy_q  <= busy_n;
      rdy_q   <= rdy_n;
      err_q   <= err_n;
      ist_q   <= ist_n;
      ie_q    <= ie_n;
      start_q <= start_n;
      idx_q   <= idx_n;
      irq_q   <= irq_n;
    end
  end

  // ---------------------------------------------------------------
  // Read mux
  // ---------------------------------------------------------------
  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      OFS_CAP: cfg_rdata = {20'd0, MSG_NUM, INTR_SUP};
      OFS_CTL: cfg_rdata[CTL_IE] = ie_q;
      OFS_STS: begin
        cfg_rdata[STS_BUSY] = busy_q;
        cfg_rdata[STS_INT]  = ist_q;
        cfg_rdata[STS_ERR]  = err_q;
        cfg_rdata[STS_RDY]  = rdy_q;
      end
      OFS_RMB: cfg_rdata = (rdy_q && (rptr_q < rcnt_q)) ? rbuf_rdata : 32'd0;
      default: cfg_rdata = '0;
    endcase
  end

  assign rsp_start    = start_q;
  assign rsp_prot_idx = idx_q;
  assign irq          = irq_q;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  assert_busy_ready_excl_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(busy_q && rdy_q));

  assert_start_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_start |-> busy_q);

  assert_bad_header_dropped_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (is_go && idle && !prot_hit) |=> (!busy_q && !rdy_q && (wcnt_q == '0)));

  assert_overflow_dropped_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (is_go && idle && ovf_q) |=> (!busy_q && !rsp_start));

  assert_notready_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!rdy_q && (cfg_addr == OFS_RMB)) |-> (cfg_rdata == 32'd0));

  assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    is_abort |=> (!busy_q && !rdy_q && !err_q && !rsp_start));

  assert_irq_has_cause_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> ((rdy_q || err_q) && ist_q));

  assert_irq_single_cycle_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |=> !irq);

endmodule

// File: tb/sim_dobj_mailbox.sv
module sim_dobj_mailbox;
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [7:0] A_CAP = 8'h04;
  localparam logic [7:0] A_CTL = 8'h08;
  localparam logic [7:0] A_STS = 8'h0C;
  localparam logic [7:0] A_WMB = 8'h10;
  localparam logic [7:0] A_RMB = 8'h14;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [3:0]  req_rd_addr;
  logic [31:0] req_rd_data;
  logic        rsp_start;
  logic [1:0]  rsp_prot_idx;
  logic        rsp_wr_en;
  logic [31:0] rsp_wr_data;
  logic        rsp_done;
  logic        rsp_discard;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dobj_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_rd_addr(req_rd_addr),
    .req_rd_data(req_rd_data), .rsp_start(rsp_start), .rsp_prot_idx(rsp_prot_idx),
    .rsp_wr_en(rsp_wr_en), .rsp_wr_data(rsp_wr_data), .rsp_done(rsp_done),
    .rsp_discard(rsp_discard), .irq(irq)
  );

  typedef struct packed {
    logic [15:0] ven;
    logic [7:0]  typ;
    logic [17:0] len;
    logic [7:0]  ndw;
    logic [7:0]  nrsp;
    logic        disp;
    logic [1:0]  idx;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{ven:16'h0001, typ:8'h00, len:18'd3, ndw:8'd3, nrsp:8'd2, disp:1'b1, idx:2'd0},
    '{ven:16'h0001, typ:8'h01, len:18'd4, ndw:8'd4, nrsp:8'd3, disp:1'b1, idx:2'd1},
    '{ven:16'hABCD, typ:8'h07, len:18'd5, ndw:8'd5, nrsp:8'd1, disp:1'b1, idx:2'd2},
    '{ven:16'hABCD, typ:8'h08, len:18'd3, ndw:8'd3, nrsp:8'd0, disp:1'b0, idx:2'd0},
    '{ven:16'h0001, typ:8'h00, len:18'd5, ndw:8'd3, nrsp:8'd0, disp:1'b0, idx:2'd0},
    '{ven:16'h0001, typ:8'h01, len:18'd2, ndw:8'd2, nrsp:8'd4, disp:1'b1, idx:2'd1},
    '{ven:16'h0002, typ:8'h00, len:18'd3, ndw:8'd3, nrsp:8'd0, disp:1'b0, idx:2'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic cwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic crd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic send_req(input logic [15:0] ven, input logic [7:0] typ,
                          input logic [17:0] len, input int ndw);
    for (int i = 0; i < ndw; i++) begin
      if (i == 0)      cwr(A_WMB, {8'h00, typ, ven});
      else if (i == 1) cwr(A_WMB, {14'd0, len});
      else             cwr(A_WMB, 32'hC0DE_0000 + i);
    end
  endtask

  // Issue go and check the dispatch pulse in the cycle after the write
  task automatic go(input string req, input logic [31:0] ctl, input logic exp_start,
                    input logic [1:0] exp_idx);
    cwr(A_CTL, ctl);
    check(req, {31'd0, rsp_start}, {31'd0, exp_start});
    if (exp_start) check(req, {30'd0, rsp_prot_idx}, {30'd0, exp_idx});
  endtask

  // Responder model: echoes request header doubleword 1 plus index
  task automatic serve(input int nrsp, input logic disc, input logic exp_irq);
    req_rd_addr = 4'd1;
    for (int i = 0; i < nrsp; i++) begin
      @(negedge clk);
      rsp_wr_en = 1'b1; rsp_wr_data = req_rd_data + i;
    end
    @(negedge clk);
    rsp_wr_en = 1'b0; rsp_done = 1'b1; rsp_discard = disc;
    @(negedge clk);
    rsp_done = 1'b0; rsp_discard = 1'b0;
    check("R12 irq pulse", {31'd0, irq}, {31'd0, exp_irq});
    @(negedge clk);
    check("R12 irq one cycle", {31'd0, irq}, 32'd0);
  endtask

  task automatic drain(input string req, input int nrsp, input logic [31:0] base);
    logic [31:0] d;
    for (int i = 0; i < nrsp; i++) begin
      crd(A_RMB, d);
      check(req, d, base + i);
      cwr(A_RMB, 32'hFFFF_FFFF);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 8'h00; cfg_wdata = '0;
    req_rd_addr = '0; rsp_wr_en = 1'b0; rsp_wr_data = '0; rsp_done = 1'b0; rsp_discard = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R2 reset state and capability
    crd(A_STS, d); check("R1 status after reset", d, 32'h0);
    crd(A_CTL, d); check("R1 control after reset", d, 32'h0);
    crd(A_CAP, d); check("R2 capability layout", d, 32'h0000_000B);

    // R3 control readback hides abort/go
    cwr(A_CTL, 32'h0000_0002);
    crd(A_CTL, d); check("R3 control shows only enable", d, 32'h0000_0002);
    go("R3 go with empty mailbox", 32'hFFFF_FFFE, 1'b0, 2'd0);
    crd(A_CTL, d); check("R3 go and abort read zero", d, 32'h0000_0002);

    // R9 read mailbox when not ready
    cwr(A_RMB, 32'h1234_5678);
    crd(A_RMB, d); check("R9 read mailbox not ready", d, 32'h0);
    crd(A_STS, d); check("R9 write ignored when not ready", d, 32'h0);

    // Vector table: R4 R5 R7 R8 R12
    for (int v = 0; v < 7; v++) begin
      send_req(VEC[v].ven, VEC[v].typ, VEC[v].len, int'(VEC[v].ndw));
      go(VEC[v].disp ? "R4 dispatch" : "R5 discard", 32'h8000_0002, VEC[v].disp, VEC[v].idx);
      crd(A_STS, d);
      if (VEC[v].disp) begin
        check("R4 busy until done", d, 32'h0000_0001);
        serve(int'(VEC[v].nrsp), 1'b0, 1'b1);
        crd(A_STS, d); check("R7 ready and interrupt status", d, 32'h8000_0002);
        crd(A_RMB, d); check("R7 first read", d, {14'd0, VEC[v].len});
        crd(A_RMB, d); check("R7 read does not advance", d, {14'd0, VEC[v].len});
        drain("R8 response order", int'(VEC[v].nrsp), {14'd0, VEC[v].len});
        crd(A_STS, d); check("R8 ready clears after last", d, 32'h0000_0002);
        crd(A_RMB, d); check("R8 read after drain", d, 32'h0);
        cwr(A_STS, 32'h0000_0002);
        crd(A_STS, d); check("R12 interrupt status clears", d, 32'h0);
      end else begin
        check("R5 nothing pending", d, 32'h0);
      end
    end

    // R6 overflow: header length equals DEPTH but DEPTH+1 written
    send_req(16'h0001, 8'h00, 18'(DEPTH), DEPTH + 1);
    go("R6 overflow discarded", 32'h8000_0002, 1'b0, 2'd0);
    crd(A_STS, d); check("R6 not busy after overflow", d, 32'h0);
    send_req(16'h0001, 8'h00, 18'd2, 2);
    go("R5 mailbox emptied after discard", 32'h8000_0002, 1'b1, 2'd0);

    // R13 go while busy ignored
    go("R13 go while busy", 32'h8000_0002, 1'b0, 2'd0);
    serve(1, 1'b0, 1'b1);
    go("R13 go while ready", 32'h8000_0002, 1'b0, 2'd0);
    crd(A_STS, d); check("R13 still ready", d, 32'h8000_0002);
    drain("R8 single word", 1, 32'd2);
    cwr(A_STS, 32'h0000_0002);

    // R10 responder discard
    send_req(16'h0001, 8'h01, 18'd3, 3);
    go("R10 dispatch", 32'h8000_0002, 1'b1, 2'd1);
    serve(2, 1'b1, 1'b1);
    crd(A_STS, d); check("R10 error set, not ready", d, 32'h0000_0006);
    crd(A_RMB, d); check("R10 read mailbox empty", d, 32'h0);

    // R11 abort clears error
    cwr(A_CTL, 32'h0000_0003);
    crd(A_STS, d); check("R11 abort clears error", d, 32'h0000_0002);
    cwr(A_STS, 32'h0000_0002);

    // R11 abort wins over go
    send_req(16'h0001, 8'h00, 18'd2, 2);
    go("R11 abort beats go", 32'h8000_0003, 1'b0, 2'd0);
    crd(A_STS, d); check("R11 idle after abort+go", d, 32'h0);

    // R11 abort while busy, late done ignored
    send_req(16'h0001, 8'h00, 18'd2, 2);
    go("R11 dispatch before abort", 32'h8000_0002, 1'b1, 2'd0);
    cwr(A_CTL, 32'h0000_0003);
    crd(A_STS, d); check("R11 abort clears busy", d, 32'h0);
    serve(1, 1'b0, 1'b0);
    crd(A_STS, d); check("R11 late done ignored", d, 32'h0);

    // R12 interrupts disabled
    send_req(16'hABCD, 8'h07, 18'd2, 2);
    go("R12 dispatch with enable off", 32'h8000_0000, 1'b1, 2'd2);
    serve(1, 1'b0, 1'b0);
    crd(A_STS, d); check("R12 no interrupt status when disabled", d, 32'h8000_0000);
    drain("R8 drain with enable off", 1, 32'd2);
    crd(A_STS, d); check("R8 idle after drain", d, 32'h0);

    finish_run();
  end

endmodule